// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single idle-high serial line into parallel characters. It watches the line on a receive tick, which is an enable pulse in the system clock domain. After a falling edge it finds the middle of each bit by counting ticks. It then shifts the data bits in, least significant first. If parity is enabled it checks the parity bit, and it then checks one stop bit. Each finished character goes into a receive buffer and raises a ready flag. A host read strobe clears that flag.

The frame shape comes from a mode byte whose field layout is shared with the matching transmitter. That byte sets the character length, the parity, the stop-bit field and the tick factor. Three error flags record problems: parity mismatch, a low stop bit, and a character lost because the previous one was never read. Each flag stays set until the host pulses the error-clear input. The line is only watched while the receive enable is high.

Top module: `async_rx`

## Requirements
- R1: While `rxEnable` is 1, a 0 seen on the idle-high line starts a frame. Data bits are taken least significant bit first.
- R2: `modeWord[3:2]` selects the character length: 00=5, 01=6, 10=7, 11=8 bits. Shorter characters appear right-aligned in `rxData`, with the unused upper bits at 0.
- R3: `modeWord[1:0]` selects the ticks per bit: 01=1, 10=16, 11=64, and 00 behaves as 1. With 16 or 64 ticks per bit, the start bit is checked on tick 8 or 32 after the tick on which the 0 was first seen, and every later bit is sampled a full bit period after the one before it. With 1 tick per bit, every bit is sampled on its own tick and there is no start check.
- R4: With 16 or 64 ticks per bit, a low pulse that has ended before the start-bit check is ignored. No character is delivered and the receiver returns to idle.
- R5: `modeWord[4]`=1 enables a parity bit after the data, and `modeWord[5]` then selects odd (1) or even (0). A mismatch sets `parityErr`.
- R6: `framingErr` is set when the first stop bit is sampled low. Only the first stop bit is checked, whatever `modeWord[7:6]` holds.
- R7: `rxReady` rises when a character is delivered and falls in the cycle after a `hostRead` pulse. If a delivery happens in the same cycle as the read, `rxReady` stays set.
- R8: If a character completes while `rxReady` is still 1 and no read happens in that cycle, `overrunErr` is set. The new character replaces the old one in `rxData`.
- R9: The three error flags are sticky. They are cleared only by `errReset`=1, and the clear takes priority over any flag being set in the same cycle.
- R10: While `rxEnable` is 0, nothing is received and the receiver is held idle. `rxData`, `rxReady` and the flags keep their values.
- R11: After reset, `rxData` is 0 and `rxReady` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWord | input | 8 | Frame format: [1:0] tick factor, [3:2] length, [4] parity enable, [5] odd parity, [7:6] stop count (not checked) |
| rxEnable | input | 1 | Receiver enable |
| errReset | input | 1 | Clears the three error flags |
| rxTick | input | 1 | Oversampling tick enable |
| rxLine | input | 1 | Serial input, idle high |
| hostRead | input | 1 | Host has taken the buffered character |
| rxData | output | 8 | Receive buffer, right-aligned |
| rxReady | output | 1 | Unread character present |
| parityErr | output | 1 | Sticky parity error |
| overrunErr | output | 1 | Sticky overrun error |
| framingErr | output | 1 | Sticky framing error |

## Verification
The bench sends frames at all three tick factors and at every character length. A design that counted ticks from the wrong point would return shifted or rotated characters. A design that misaligned short characters would leave stale upper bits set. The bench also sends a start pulse shorter than half a bit, which a receiver without the start-bit check would turn into a spurious character. Further tests use a frame with the parity bit inverted, a frame with a low stop bit, two frames sent without a read in between, and a frame sent while the receiver is disabled. These expose flags that do not stick, flags that clear too early, overrun that is missed, and reception that does not stop when disabled.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int OSR_HI = 64;
  localparam int CNT_W  = $clog2(OSR_HI);
  localparam int CHAR_W = 8;
  localparam int BIT_W  = $clog2(CHAR_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rxState_e;

  typedef struct packed {
    logic clearShift;
    logic shiftIn;
    logic takeParity;
    logic finishFrame;
  } rxStrobe_t;

  // ticks per bit minus one for the selected factor
  function automatic logic [CNT_W-1:0] factorM1(input logic [1:0] sel);
    case (sel)
      2'b10:   factorM1 = CNT_W'(15);
      2'b11:   factorM1 = CNT_W'(OSR_HI - 1);
      default: factorM1 = '0;
    endcase
  endfunction
endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      rxTick,
  input  logic      lineS,
  input  logic [1:0] baudSel,
  input  logic [1:0] lenSel,
  input  logic      parEn,
  output rxStrobe_t strb
);
  rxState_e         state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic [BIT_W-1:0] bitIdx, bitIdxNx;
  logic [CNT_W-1:0] fM1, halfM1;
  logic [BIT_W-1:0] charLast;

  assign fM1      = factorM1(baudSel);
  assign halfM1   = fM1 >> 1;
  assign charLast = BIT_W'(3'd4 + {1'b0, lenSel});

  always_comb begin
    stateNx  = state;
    cntNx    = cnt;
    bitIdxNx = bitIdx;
    strb     = '0;
    if (!rxEnable) begin
      stateNx = ST_IDLE;
      cntNx   = '0;
    end else if (rxTick) begin
      case (state)
        ST_IDLE: begin
          if (!lineS) begin
            strb.clearShift = 1'b1;
            cntNx    = '0;
            bitIdxNx = '0;
            stateNx  = (fM1 == '0) ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (cnt == halfM1) begin
            cntNx   = '0;
            stateNx = lineS ? ST_IDLE : ST_DATA;
          end else begin
            cntNx = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == fM1) begin
            strb.shiftIn = 1'b1;
            cntNx    = '0;
            bitIdxNx = bitIdx + 1'b1;
            if (bitIdx == charLast) stateNx = parEn ? ST_PAR : ST_STOP;
          end else begin
            cntNx = cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == fM1) begin
            strb.takeParity = 1'b1;
            cntNx   = '0;
            stateNx = ST_STOP;
          end else begin
            cntNx = cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == fM1) begin
            strb.finishFrame = 1'b1;
            cntNx   = '0;
            stateNx = ST_IDLE;
          end else begin
            cntNx = cnt + 1'b1;
          end
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNx;
      cnt    <= cntNx;
      bitIdx <= bitIdxNx;
    end
  end
endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strb,
  input  logic [1:0]        lenSel,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              errReset,
  input  logic              hostRead,
  output logic              lineS,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              framingErr
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [CHAR_W-1:0]      shReg;
  logic                   parBit;
  logic [CHAR_W-1:0]      aligned;
  logic                   parBad;

  assign lineS   = syncQ[SYNC_STAGES-1];
  assign aligned = shReg >> (~lenSel);
  assign parBad  = parEn && ((^shReg ^ parBit) != parOdd);

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else if (strb.clearShift) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else begin
      if (strb.shiftIn)    shReg  <= {lineS, shReg[CHAR_W-1:1]};
      if (strb.takeParity) parBit <= lineS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      if (strb.finishFrame) begin
        rxData  <= aligned;
        rxReady <= 1'b1;
      end else if (hostRead) begin
        rxReady <= 1'b0;
      end
      if (errReset) begin
        parityErr  <= 1'b0;
        overrunErr <= 1'b0;
        framingErr <= 1'b0;
      end else if (strb.finishFrame) begin
        if (parBad)               parityErr  <= 1'b1;
        if (!lineS)               framingErr <= 1'b1;
        if (rxReady && !hostRead) overrunErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] modeWord,
  input  logic       rxEnable,
  input  logic       errReset,
  input  logic       rxTick,
  input  logic       rxLine,
  input  logic       hostRead,
  output logic [7:0] rxData,
  output logic       rxReady,
  output logic       parityErr,
  output logic       overrunErr,
  output logic       framingErr
);
  rxStrobe_t ctrlStrb;
  logic      lineS;
  logic      frameDone;
  logic      unusedStop;

  assign frameDone  = ctrlStrb.finishFrame;
  assign unusedStop = ^modeWord[7:6];

  async_rx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnable (rxEnable),
    .rxTick   (rxTick),
    .lineS    (lineS),
    .baudSel  (modeWord[1:0]),
    .lenSel   (modeWord[3:2]),
    .parEn    (modeWord[4]),
    .strb     (ctrlStrb)
  );

  async_rx_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .strb       (ctrlStrb),
    .lenSel     (modeWord[3:2]),
    .parEn      (modeWord[4]),
    .parOdd     (modeWord[5]),
    .errReset   (errReset),
    .hostRead   (hostRead),
    .lineS      (lineS),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .parityErr  (parityErr),
    .overrunErr (overrunErr),
    .framingErr (framingErr)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       errReset,
  input logic       hostRead,
  input logic       frameDone,
  input logic [7:0] rxData,
  input logic       rxReady,
  input logic       parityErr,
  input logic       overrunErr,
  input logic       framingErr
);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    hostRead && !frameDone |=> !rxReady);

  a_r7_done_sets_ready: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> rxReady);

  a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && rxReady && !hostRead && !errReset |=> overrunErr);

  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    errReset |=> !parityErr && !overrunErr && !framingErr);

  a_r9_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parityErr && !errReset |=> parityErr);

  a_r9_framing_sticky: assert property (@(posedge clk) disable iff (!rstN)
    framingErr && !errReset |=> framingErr);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr && !errReset |=> overrunErr);

  a_r10_no_frame_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> !frameDone);

  a_r10_buffer_holds: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> $stable(rxData));
endmodule

bind async_rx async_rx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .errReset   (errReset),
  .hostRead   (hostRead),
  .frameDone  (frameDone),
  .rxData     (rxData),
  .rxReady    (rxReady),
  .parityErr  (parityErr),
  .overrunErr (overrunErr),
  .framingErr (framingErr)
);

// File: tb/sim_async_rx.sv
`timescale 1ns/1ps
module sim_async_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] modeWord = 8'h4E;
  logic       rxEnable = 1'b1;
  logic       errReset = 1'b0;
  logic       rxTick = 1'b1;
  logic       rxLine = 1'b1;
  logic       hostRead = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, parityErr, overrunErr, framingErr;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  async_rx u0 (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .rxEnable(rxEnable),
    .errReset(errReset), .rxTick(rxTick), .rxLine(rxLine), .hostRead(hostRead),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .overrunErr(overrunErr), .framingErr(framingErr)
  );

  // {mode, data, flipParity, stopLow, expData, expParErr, expFrmErr}
  localparam int NVEC = 8;
  localparam logic [27:0] VEC [NVEC] = '{
    {8'h4E, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {8'h5D, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {8'h7B, 8'hD5, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    {8'h42, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {8'h56, 8'h2A, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0},
    {8'h4E, 8'h81, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
    {8'h7C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {8'hCE, 8'h5A, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ticksPerBit(input logic [1:0] sel);
    case (sel)
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 1;
    endcase
  endfunction

  task automatic sendFrame(input logic [7:0] mode, input logic [7:0] data,
                           input logic flipPar, input logic stopLow);
    int f;
    int len;
    logic par;
    f   = ticksPerBit(mode[1:0]);
    len = 5 + int'(mode[3:2]);
    par = mode[5] ^ flipPar;
    @(negedge clk);
    rxLine = 1'b0;
    repeat (f) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxLine = data[i];
      par = par ^ data[i];
      repeat (f) @(negedge clk);
    end
    if (mode[4]) begin
      rxLine = par;
      repeat (f) @(negedge clk);
    end
    rxLine = ~stopLow;
    repeat (f) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * f + 8) @(negedge clk);
  endtask

  task automatic pulseRead();
    @(negedge clk); hostRead = 1'b1;
    @(negedge clk); hostRead = 1'b0;
  endtask

  task automatic pulseErrReset();
    @(negedge clk); errReset = 1'b1;
    @(negedge clk); errReset = 1'b0;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 rxData", rxData, 8'h00);
    check("R11 rxReady", {7'd0, rxReady}, 8'd0);
    check("R11 flags", {5'd0, parityErr, overrunErr, framingErr}, 8'd0);

    // R1 R2 R3 R5 R6 R7: table of frames
    for (int v = 0; v < NVEC; v++) begin
      logic [27:0] e;
      e = VEC[v];
      modeWord = e[27:20];
      sendFrame(e[27:20], e[19:12], e[11], e[10]);
      check("R1 R2 R3 data", rxData, e[9:2]);
      check("R7 ready set", {7'd0, rxReady}, 8'd1);
      check("R5 parity flag", {7'd0, parityErr}, {7'd0, e[1]});
      check("R6 framing flag", {7'd0, framingErr}, {7'd0, e[0]});
      check("R8 no overrun", {7'd0, overrunErr}, 8'd0);
      pulseRead();
      check("R7 ready cleared", {7'd0, rxReady}, 8'd0);
      pulseErrReset();
    end

    // R4: short low pulse ignored (x16 and x64)
    modeWord = 8'h4E;
    @(negedge clk); rxLine = 1'b0;
    repeat (5) @(negedge clk); rxLine = 1'b1;
    repeat (200) @(negedge clk);
    check("R4 glitch x16 no char", {7'd0, rxReady}, 8'd0);
    modeWord = 8'h4F;
    @(negedge clk); rxLine = 1'b0;
    repeat (20) @(negedge clk); rxLine = 1'b1;
    repeat (800) @(negedge clk);
    check("R4 glitch x64 no char", {7'd0, rxReady}, 8'd0);
    modeWord = 8'h4E;
    sendFrame(8'h4E, 8'h6B, 1'b0, 1'b0);
    check("R4 char after glitch", rxData, 8'h6B);
    pulseRead();

    // R8: two frames without read
    sendFrame(8'h4E, 8'hA1, 1'b0, 1'b0);
    sendFrame(8'h4E, 8'hB2, 1'b0, 1'b0);
    check("R8 overrun set", {7'd0, overrunErr}, 8'd1);
    check("R8 newest kept", rxData, 8'hB2);

    // R9: flag sticks across read and a clean frame
    pulseRead();
    sendFrame(8'h4E, 8'hC3, 1'b0, 1'b0);
    check("R9 overrun sticky", {7'd0, overrunErr}, 8'd1);
    check("R9 clean data", rxData, 8'hC3);
    pulseRead();
    pulseErrReset();
    check("R9 flags cleared", {5'd0, parityErr, overrunErr, framingErr}, 8'd0);

    // R10: disabled receiver ignores a frame
    rxEnable = 1'b0;
    sendFrame(8'h4E, 8'h77, 1'b0, 1'b0);
    check("R10 no ready when off", {7'd0, rxReady}, 8'd0);
    check("R10 buffer kept", rxData, 8'hC3);
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);
    sendFrame(8'h4E, 8'h11, 1'b0, 1'b0);
    check("R10 works after enable", rxData, 8'h11);
    check("R10 ready after enable", {7'd0, rxReady}, 8'd1);

    finishRun();
  end
endmodule